// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Digital Lock Filter

This block compares two divided pulse trains, a feedback train and a reference train, that are synchronous to the system clock. It looks only at their rising edges. When the reference edge comes first, it drives a low pulse on the active-low up output. When the feedback edge comes first, it drives a low pulse on the active-low down output. The pulse lasts from the leading edge until the trailing edge is seen, so its width in clock cycles grows with the phase error. Once both edges have been seen, both sides clear together. The up and down outputs are meant to feed a loop filter outside this block.

A raw lock signal is also provided. It is high whenever either output is low. A digital integrator stands in for an external capacitor. It is a saturating counter that counts clean cycles and clears on any one-sided error pulse. The lock flag rises once the count reaches a threshold given at a port. A disable input holds the lock flag low without stopping the integrator.

Top module: `pfd_lock_detect`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `up_n_o`=1, `dn_n_o`=1, `raw_o`=0 and `lock_o`=0, and the lock counter is zero.
- R2: Falling edges and inputs held high or low start no pulse. With no new rising edge, both outputs stay high.
- R3: If `fc_i` rises d≥1 cycles before `fp_i`, then `up_n_o` is low for d+1 cycles. The first low cycle comes one clock after the rising `fc_i` is sampled. `dn_n_o` is low for exactly one cycle, and that cycle is the last low cycle of `up_n_o`.
- R4: If `fp_i` rises d≥1 cycles before `fc_i`, the result mirrors R3 with `dn_n_o` and `up_n_o` swapped.
- R5: If both inputs rise in the same sampled cycle, both outputs are low for exactly one cycle and then both return high.
- R6: `raw_o` is the NAND of `up_n_o` and `dn_n_o`, which means it is high in every cycle where either output is low.
- R7: Any cycle where exactly one output is low clears the lock counter at the next edge. Every other cycle increments it. The counter saturates at 2^CNT_W−1 and does not wrap.
- R8: `lock_o` is high when the counter is at least `lock_thresh_i`. A threshold of 0 behaves as 1. Out of reset with idle inputs, lock first shows in the sampled cycle number max(thresh,1).
- R9: `ld_dis_i`=1 forces `lock_o` low in the same cycle. The counter keeps running, so releasing the disable restores the lock at once if the count is still high enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fp_i | input | 1 | Divided feedback pulse train |
| fc_i | input | 1 | Divided reference pulse train |
| ld_dis_i | input | 1 | Lock-flag disable, active high |
| lock_thresh_i | input | CNT_W | Clean-cycle count needed for lock |
| up_n_o | output | 1 | Active-low up pulse (reference leads) |
| dn_n_o | output | 1 | Active-low down pulse (feedback leads) |
| raw_o | output | 1 | NAND of the two pulse outputs |
| lock_o | output | 1 | Filtered lock flag |

## Verification
The bench drives a rising edge at a falling clock edge. A pulse output answers one clock later: the edge sampler is combinational and the state flip-flop is the only register on the path. The lock flag depends on the counter, so it drops two sampled cycles after the leading edge and returns T cycles after the overlap cycle. Every check samples at the falling edge, indexed from the stimulus. The exact first-low index, the low-cycle count and the lock index are compared against arithmetic over d and T for each lead, each skew 0 to 6 and each threshold in the sweep.

// File: rtl/pfd_pkg.sv
// Package: shared lane indices and the detector state type.
// Assumes: lanes are indexed fp first, fc second.
package pfd_pkg;
    localparam int unsigned LANES   = 2;
    localparam int unsigned LANE_FP = 0;
    localparam int unsigned LANE_FC = 1;

    typedef struct packed {
        logic up;   // reference edge seen, waiting for feedback
        logic dn;   // feedback edge seen, waiting for reference
    } pfd_state_t;
endpackage

// File: rtl/pfd_edge_det.sv
// Module: rising-edge detector, one lane per input bit.
// Assumes: inputs are synchronous to clk; a lane high on reset release
// counts as a rise.
module pfd_edge_det #(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] sig_i,
    output logic [LANES-1:0] rise_o
);
    logic [LANES-1:0] prev_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Remember the previous sample of this lane.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q[g] <= 1'b0;
            else        prev_q[g] <= sig_i[g];
        end
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end
endmodule

// File: rtl/pfd_core.sv
// Module: three-state detector core with active-high internal state.
// Assumes: edge pulses last one cycle; an edge that lands in the
// clearing cycle (both flags set) is discarded.
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fp_rise_i,
    input  logic       fc_rise_i,
    output pfd_state_t st_o
);
    pfd_state_t st_q;

    // Set a flag on its edge; clear both one cycle after both are set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (st_q.up && st_q.dn) begin
            st_q <= '0;
        end else begin
            st_q.up <= st_q.up | fc_rise_i;
            st_q.dn <= st_q.dn | fp_rise_i;
        end
    end

    assign st_o = st_q;

    // R5
    both_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && st_q.dn) |=> (!st_q.up && !st_q.dn));
    // R2
    no_spurious_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.up && !fc_rise_i) |=> !st_q.up);
    // R2
    no_spurious_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.dn && !fp_rise_i) |=> !st_q.dn);
    // R3
    up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.up && !st_q.dn) |=> st_q.up);
endmodule

// File: rtl/pfd_lock_filter.sv
// Module: saturating clean-cycle counter that stands in for the
// integrating capacitor, plus threshold compare and disable gating.
// Assumes: err_i is high only in cycles with a one-sided pulse.
module pfd_lock_filter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             ld_dis_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             lock_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] eff_thresh;

    // Clear on error, else count up and hold at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (err_i)            cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
    end

    // Treat a zero threshold as one so reset always deasserts lock.
    always_comb begin
        eff_thresh = (thresh_i == '0) ? CNT_ONE : thresh_i;
    end

    assign lock_o = !ld_dis_i && (cnt_q >= eff_thresh);

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> (cnt_q == '0));
    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !err_i) |=> (cnt_q == CNT_MAX));
    // R8
    lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_o && err_i) |=> !lock_o);
endmodule

// File: rtl/pfd_lock_detect.sv
// Module: top level. It ties the edge detector, the detector core and the
// lock filter together and drives the active-low pulse outputs.
// Assumes: fp_i and fc_i are synchronous to clk and held low in reset.
module pfd_lock_detect
    import pfd_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_i,
    input  logic             fc_i,
    input  logic             ld_dis_i,
    input  logic [CNT_W-1:0] lock_thresh_i,
    output logic             up_n_o,
    output logic             dn_n_o,
    output logic             raw_o,
    output logic             lock_o
);
    logic [LANES-1:0] in_vec;
    logic [LANES-1:0] rise_vec;
    pfd_state_t       st;
    logic             err;

    // Pack the two inputs into the lane vector.
    always_comb begin
        in_vec          = '0;
        in_vec[LANE_FP] = fp_i;
        in_vec[LANE_FC] = fc_i;
    end

    pfd_edge_det #(.LANES(LANES)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (in_vec),
        .rise_o (rise_vec)
    );

    pfd_core core_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_rise_i (rise_vec[LANE_FP]),
        .fc_rise_i (rise_vec[LANE_FC]),
        .st_o      (st)
    );

    // The one-sided state is an error; the overlap cycle is the reset window.
    assign err    = st.up ^ st.dn;
    assign up_n_o = ~st.up;
    assign dn_n_o = ~st.dn;
    assign raw_o  = ~(up_n_o & dn_n_o);

    pfd_lock_filter #(.CNT_W(CNT_W)) filt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_i    (err),
        .ld_dis_i (ld_dis_i),
        .thresh_i (lock_thresh_i),
        .lock_o   (lock_o)
    );
endmodule

// File: tb/pfd_lock_detect_tb_top.sv
module pfd_lock_detect_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;
    localparam int LOCK_T     = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fp_i, fc_i, ld_dis_i;
    logic [CNT_W-1:0] lock_thresh_i;
    logic             up_n_o, dn_n_o, raw_o, lock_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  reported = 1'b0;

    pfd_lock_detect #(.CNT_W(CNT_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .fp_i          (fp_i),
        .fc_i          (fc_i),
        .ld_dis_i      (ld_dis_i),
        .lock_thresh_i (lock_thresh_i),
        .up_n_o        (up_n_o),
        .dn_n_o        (dn_n_o),
        .raw_o         (raw_o),
        .lock_o        (lock_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
        end
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_raw();
        chk(raw_o == (!up_n_o || !dn_n_o), "R6 raw", int'(raw_o),
            int'(!up_n_o || !dn_n_o));
    endtask

    // Leader rises at sample 0, follower d samples later.
    task automatic run_pair(input bit lead_fc, input int d);
        int first_up = -1, first_dn = -1, cnt_up = 0, cnt_dn = 0;
        int first_ld, cnt_ld, first_fl, cnt_fl;
        string req;
        bit exp_lock;
        req = (d == 0) ? "R5" : (lead_fc ? "R3" : "R4");
        if (lead_fc) fc_i = 1'b1; else fp_i = 1'b1;
        if (d == 0) begin fc_i = 1'b1; fp_i = 1'b1; end
        for (int i = 1; i <= d + 6; i++) begin
            step();
            if (!up_n_o) begin cnt_up++; if (first_up < 0) first_up = i; end
            if (!dn_n_o) begin cnt_dn++; if (first_dn < 0) first_dn = i; end
            chk_raw();
            // R7/R8: lock drops after the first error cycle, returns T after overlap
            exp_lock = (d == 0) || (i == 1) || (i >= d + 1 + LOCK_T);
            chk(lock_o == exp_lock, "R7 R8 lock during pulse", int'(lock_o), int'(exp_lock));
            if (i == d && d > 0) begin fc_i = 1'b1; fp_i = 1'b1; end
        end
        first_ld = lead_fc ? first_up : first_dn;
        cnt_ld   = lead_fc ? cnt_up   : cnt_dn;
        first_fl = lead_fc ? first_dn : first_up;
        cnt_fl   = lead_fc ? cnt_dn   : cnt_up;
        chk(first_ld == 1,     {req, " leader first low"}, first_ld, 1);
        chk(cnt_ld == d + 1,   {req, " leader width"},     cnt_ld,   d + 1);
        chk(first_fl == d + 1, {req, " follower first low"}, first_fl, d + 1);
        chk(cnt_fl == 1,       {req, " follower width"},   cnt_fl,   1);
        // R2: falling edges start nothing
        fc_i = 1'b0; fp_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            step();
            chk(up_n_o && dn_n_o, "R2 falling edges ignored", int'({up_n_o, dn_n_o}), 3);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
        $finish;
    end

    initial begin
        int teff;
        int tlist [5] = '{0, 1, 3, 5, 15};
        rst_n = 1'b0; fp_i = 1'b0; fc_i = 1'b0; ld_dis_i = 1'b0;
        lock_thresh_i = CNT_W'(LOCK_T);
        repeat (3) step();
        // R1 reset state
        chk(up_n_o == 1'b1, "R1 up_n reset", int'(up_n_o), 1);
        chk(dn_n_o == 1'b1, "R1 dn_n reset", int'(dn_n_o), 1);
        chk(raw_o == 1'b0,  "R1 raw reset",  int'(raw_o), 0);
        chk(lock_o == 1'b0, "R1 lock reset", int'(lock_o), 0);

        // R8 ramp from reset for several thresholds; R7 saturation at 15
        foreach (tlist[t]) begin
            rst_n = 1'b0;
            lock_thresh_i = CNT_W'(tlist[t]);
            step(); step();
            chk(lock_o == 1'b0, "R1 lock in reset", int'(lock_o), 0);
            rst_n = 1'b1;
            teff = (tlist[t] == 0) ? 1 : tlist[t];
            for (int k = 1; k <= teff + 25; k++) begin
                step();
                chk(lock_o == (k >= teff), (k > 15) ? "R7 saturate" : "R8 ramp",
                    int'(lock_o), int'(k >= teff));
                chk(up_n_o && dn_n_o, "R2 idle inputs", int'({up_n_o, dn_n_o}), 3);
            end
        end

        // R9 disable gating
        ld_dis_i = 1'b1;
        #1;
        chk(lock_o == 1'b0, "R9 disable immediate", int'(lock_o), 0);
        step();
        chk(lock_o == 1'b0, "R9 disable held", int'(lock_o), 0);
        ld_dis_i = 1'b0;
        #1;
        chk(lock_o == 1'b1, "R9 release restores", int'(lock_o), 1);

        // R3/R4/R5 sweep of lead side and skew
        lock_thresh_i = CNT_W'(LOCK_T);
        step();
        for (int lead = 0; lead < 2; lead++) begin
            for (int d = 0; d <= 6; d++) begin
                repeat (LOCK_T + 2) step();
                chk(lock_o == 1'b1, "R8 relocked before pair", int'(lock_o), 1);
                run_pair(lead == 1, d);
            end
        end

        report();
        $finish;
    end
endmodule